// File: doc/BRIEF.md
# Overlay Vertical Line Position Counter

This block finds the vertical position of an on-screen overlay by counting scan lines. Raw horizontal and vertical sync signals arrive from off chip. Each one passes through a two-flop synchronizer, and a per-signal polarity bit then picks which edge is the active one. Every active vertical sync edge clears the line count to zero. From there, each active horizontal sync edge adds one to the count.

Right after the vertical edge there is a short blanking window. A horizontal edge inside that window is not counted. This keeps a horizontal edge that lands almost on top of the vertical edge from making the first line jitter between frames.

The block compares the count with a programmed start line and gives a one-clock pulse on the horizontal edge that brings the count to that line. The count saturates instead of wrapping when vertical sync goes missing. A separate one-clock flag reports any sync pulse on either input that is shorter than the minimum width.

Top module: `osd_vpos_counter`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `line_count` is 0 and `start_hit` and `timing_err` are 0.
- R2: `pol_sel[0]` sets the horizontal sync polarity and `pol_sel[1]` sets the vertical sync polarity. A bit at 0 makes the rising edge active. A bit at 1 makes the falling edge active.
- R3: Each counted active horizontal edge raises `line_count` by exactly one.
- R4: An active vertical edge sets `line_count` to 0.
- R5: An active horizontal edge is counted only if it comes at least 2 clock cycles after the last active vertical edge. An edge 0 or 1 cycles after it is skipped.
- R6: `line_count` stops at 1023 and never wraps while no vertical edge comes.
- R7: `start_hit` is high for exactly one clock, in the same cycle in which `line_count` first shows a value equal to `start_line`. That value must have been reached by a counted horizontal edge. A `start_line` of 0 never produces a hit.
- R8: `timing_err` pulses for one clock when an active pulse on either sync input ends after fewer than 8 cycles. Pulses of 8 cycles or more do not raise it.
- R9: A sync input change made before clock edge N is seen on `line_count`, `start_hit` and `timing_err` after edge N+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one machine cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Raw horizontal sync, asynchronous |
| vsync_in | input | 1 | Raw vertical sync, asynchronous |
| pol_sel | input | 2 | Bit 0: horizontal polarity. Bit 1: vertical polarity. 1 means falling edge active |
| start_line | input | 10 | Programmed vertical start line |
| line_count | output | 10 | Current line count since the last vertical edge |
| start_hit | output | 1 | One-clock pulse when the count reaches `start_line` |
| timing_err | output | 1 | One-clock pulse on a sync pulse shorter than the minimum |

## Verification
The hardest case to reach from the ports is the exact spacing between an active vertical edge and the next active horizontal edge. Only the offsets 0, 1 and 2 cycles separate a skipped edge from a counted one. The bench builds every frame cycle by cycle. It places the first horizontal edge at offsets 0 to 4 cycles after the vertical edge, under all four polarity settings. Saturation needs more than a thousand lines without any vertical edge, so one long frame omits the vertical pulse entirely.

// File: rtl/osd_vpos_pkg.sv
package osd_vpos_pkg;

    localparam int LINE_W      = 10;
    localparam int SYNC_STAGES = 2;
    localparam int BLANK_CYC   = 2;
    localparam int MIN_PULSE   = 8;

    // Polarity encoding of one pol_sel bit
    typedef enum logic {
        POL_RISE = 1'b0,
        POL_FALL = 1'b1
    } sync_pol_e;

    // Synchronized view of one sync input after polarity is applied
    typedef struct packed {
        logic level;   // active level present
        logic act;     // entry into the active level
        logic inact;   // return to the inactive level
    } sync_ev_t;

    // Map a raw synchronized level to "active" under a polarity
    function automatic logic apply_pol(input logic raw, input sync_pol_e pol);
        return (pol == POL_FALL) ? ~raw : raw;
    endfunction

endpackage

// File: rtl/osd_sync_edge.sv
module osd_sync_edge
    import osd_vpos_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    input  logic      pol,
    output sync_ev_t  ev
);

    localparam int MSB = STAGES - 1;

    logic [STAGES-1:0] sr;
    logic              prev_raw;
    logic              lvl_now;
    logic              lvl_was;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr       <= '0;
            prev_raw <= 1'b0;
        end else begin
            sr       <= {sr[MSB-1:0], din};
            prev_raw <= sr[MSB];
        end
    end

    always_comb begin
        lvl_now  = apply_pol(sr[MSB], sync_pol_e'(pol));
        lvl_was  = apply_pol(prev_raw, sync_pol_e'(pol));
        ev.level = lvl_now;
        ev.act   = lvl_now & ~lvl_was;
        ev.inact = ~lvl_now & lvl_was;
    end

endmodule

// File: rtl/osd_pulse_width.sv
module osd_pulse_width
    import osd_vpos_pkg::*;
#(
    parameter int MIN_W = MIN_PULSE
) (
    input  logic     clk,
    input  logic     rst,
    input  sync_ev_t ev,
    output logic     short_pulse
);

    localparam int            CW   = $clog2(MIN_W + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_W);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic          in_pulse;
    logic [CW-1:0] width;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pulse <= 1'b0;
            width    <= '0;
        end else if (ev.act) begin
            in_pulse <= 1'b1;
            width    <= ONE;
        end else if (ev.inact) begin
            in_pulse <= 1'b0;
        end else if (in_pulse && ev.level && (width != CMAX)) begin
            width <= width + ONE;
        end
    end

    always_comb begin
        short_pulse = ev.inact && in_pulse && (width < CMAX);
    end

endmodule

// File: rtl/osd_line_ctr.sv
module osd_line_ctr
    import osd_vpos_pkg::*;
#(
    parameter int LW    = LINE_W,
    parameter int BLANK = BLANK_CYC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hs_act,
    input  logic          vs_act,
    input  logic [LW-1:0] start_line,
    output logic [LW-1:0] line_count,
    output logic          start_hit
);

    localparam int            BW        = $clog2(BLANK + 1);
    localparam logic [BW-1:0] BLANK_LD  = BW'(BLANK - 1);
    localparam logic [LW-1:0] LINE_MAX  = {LW{1'b1}};
    localparam logic [LW-1:0] LINE_ONE  = LW'(1);

    logic [BW-1:0] blank_left;
    logic          take_edge;
    logic [LW-1:0] next_line;

    always_comb begin
        take_edge = hs_act && !vs_act && (blank_left == '0);
        next_line = line_count + LINE_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_count <= '0;
            start_hit  <= 1'b0;
            blank_left <= '0;
        end else begin
            start_hit <= 1'b0;
            if (vs_act) begin
                line_count <= '0;
                blank_left <= BLANK_LD;
            end else begin
                if (blank_left != '0) begin
                    blank_left <= blank_left - BW'(1);
                end
                if (take_edge && (line_count != LINE_MAX)) begin
                    line_count <= next_line;
                    start_hit  <= (next_line == start_line);
                end
            end
        end
    end

endmodule

// File: rtl/osd_vpos_counter.sv
module osd_vpos_counter
    import osd_vpos_pkg::*;
#(
    parameter int LW     = LINE_W,
    parameter int STAGES = SYNC_STAGES,
    parameter int BLANK  = BLANK_CYC,
    parameter int MIN_W  = MIN_PULSE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hsync_in,
    input  logic          vsync_in,
    input  logic [1:0]    pol_sel,
    input  logic [LW-1:0] start_line,
    output logic [LW-1:0] line_count,
    output logic          start_hit,
    output logic          timing_err
);

    localparam int NSRC = 2;   // index 0: horizontal, 1: vertical

    logic [NSRC-1:0] raw_in;
    sync_ev_t        ev    [NSRC];
    logic [NSRC-1:0] short_p;
    logic            hs_act, vs_act, hs_inact, vs_inact;

    assign raw_in = {vsync_in, hsync_in};

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        osd_sync_edge #(.STAGES(STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw_in[i]),
            .pol (pol_sel[i]),
            .ev  (ev[i])
        );
        osd_pulse_width #(.MIN_W(MIN_W)) u_width (
            .clk         (clk),
            .rst         (rst),
            .ev          (ev[i]),
            .short_pulse (short_p[i])
        );
    end

    assign hs_act   = ev[0].act;
    assign vs_act   = ev[1].act;
    assign hs_inact = ev[0].inact;
    assign vs_inact = ev[1].inact;

    osd_line_ctr #(.LW(LW), .BLANK(BLANK)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .hs_act     (hs_act),
        .vs_act     (vs_act),
        .start_line (start_line),
        .line_count (line_count),
        .start_hit  (start_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) timing_err <= 1'b0;
        else     timing_err <= |short_p;
    end

endmodule

// File: rtl/osd_vpos_checker.sv
module osd_vpos_checker #(
    parameter int LW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          hs_act,
    input logic          vs_act,
    input logic          hs_inact,
    input logic          vs_inact,
    input logic [LW-1:0] start_line,
    input logic [LW-1:0] line_count,
    input logic          start_hit,
    input logic          timing_err
);

    localparam logic [LW-1:0] LMAX = {LW{1'b1}};

    AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        start_hit |=> !start_hit); // R7

    AST_HIT_VALUE: assert property (@(posedge clk) disable iff (rst)
        start_hit |-> (line_count == $past(start_line)) && (line_count != '0)); // R7

    AST_VSYNC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        vs_act |=> (line_count == '0)); // R4

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !vs_act |=> (line_count == $past(line_count)) ||
                    (line_count == $past(line_count) + LW'(1))); // R3

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (line_count == LMAX) && !vs_act |=> (line_count == LMAX)); // R6

    AST_BLANK_SKIP: assert property (@(posedge clk) disable iff (rst)
        hs_act && $past(vs_act) |=> (line_count == '0)); // R5

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        timing_err |-> $past(hs_inact || vs_inact)); // R8

endmodule

bind osd_vpos_counter osd_vpos_checker #(.LW(LW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hs_act     (hs_act),
    .vs_act     (vs_act),
    .hs_inact   (hs_inact),
    .vs_inact   (vs_inact),
    .start_line (start_line),
    .line_count (line_count),
    .start_hit  (start_hit),
    .timing_err (timing_err)
);

// File: tb/tb_osd_vpos_counter.sv
`timescale 1ns/1ps
module tb_osd_vpos_counter;

    logic       clk = 1'b0;
    logic       rst;
    logic       hsync_in, vsync_in;
    logic [1:0] pol_sel;
    logic [9:0] start_line;
    logic [9:0] line_count;
    logic       start_hit, timing_err;

    int n_run  = 0;
    int n_fail = 0;
    int hit_n  = 0;
    int hit_val = 0;
    int err_n  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    osd_vpos_counter dut (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .pol_sel(pol_sel), .start_line(start_line),
        .line_count(line_count), .start_hit(start_hit), .timing_err(timing_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (start_hit) begin hit_n++; hit_val = int'(line_count); end
            if (timing_err) err_n++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hsync_in = pol_sel[0];
            vsync_in = pol_sel[1];
        end
    endtask

    task automatic do_reset(input logic [1:0] p);
        @(negedge clk);
        pol_sel  = p;
        rst      = 1'b1;
        hsync_in = p[0];
        vsync_in = p[1];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(4);
        hit_n = 0; err_n = 0;
    endtask

    // Frame: vertical pulse of vw cycles from cycle 0 (none if vw == 0),
    // nl horizontal pulses of hw cycles, period 16, first at cycle d.
    task automatic run_frame(input int d, input int nl, input int vw, input int hw);
        int total;
        bit va, ha;
        total = d + 16 * nl + 8;
        if (vw + 8 > total) total = vw + 8;
        hit_n = 0; err_n = 0;
        for (int c = 0; c < total; c++) begin
            @(negedge clk);
            va = (c < vw);
            ha = (c >= d) && (((c - d) % 16) < hw) && (((c - d) / 16) < nl);
            vsync_in = va ^ pol_sel[1];
            hsync_in = ha ^ pol_sel[0];
        end
        idle(6);
    endtask

    initial begin
        #(5.0 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int exp_cnt, exp_hits, sl;
        rst = 1'b1; pol_sel = 2'b00; start_line = '0;
        hsync_in = 1'b0; vsync_in = 1'b0;

        // R1 reset state, under each polarity
        for (int p = 0; p < 4; p++) begin
            do_reset(p[1:0]);
            chk("R1 count after reset", int'(line_count), 0);
            chk("R1 hit after reset", int'(start_hit), 0);
            chk("R1 err after reset", int'(timing_err), 0);
        end

        // R2 R3 R4 R5 R7: polarity x offset x line count x start line sweep
        for (int p = 0; p < 4; p++) begin
            do_reset(p[1:0]);
            for (int d = 0; d < 5; d++) begin
                for (int k = 0; k < 3; k++) begin
                    int nl;
                    nl = 1 + 2 * k;
                    sl = (d + nl) % 6;
                    start_line = 10'(sl);
                    run_frame(d, nl, 8, 8);
                    exp_cnt  = nl - ((d < 2) ? 1 : 0);
                    exp_hits = (sl >= 1 && sl <= exp_cnt) ? 1 : 0;
                    chk("R2_R3_R5 line count", int'(line_count), exp_cnt);
                    chk("R7 hit pulses", hit_n, exp_hits);
                    if (exp_hits == 1) chk("R7 hit line", hit_val, sl);
                    chk("R8 no err on legal widths", err_n, 0);
                end
            end
        end

        // R8 width sweep on both inputs
        for (int p = 0; p < 4; p += 3) begin
            do_reset(p[1:0]);
            start_line = '0;
            for (int w = 4; w <= 10; w++) begin
                run_frame(4, 3, w, 8);
                chk("R8 short vertical pulse", err_n, (w < 8) ? 1 : 0);
                chk("R4 count after frame", int'(line_count), 3);
                run_frame(4, 3, 8, w);
                chk("R8 short horizontal pulses", err_n, (w < 8) ? 3 : 0);
            end
        end

        // R9 latency of one counted edge
        do_reset(2'b00);
        start_line = 10'd1;
        run_frame(4, 0, 8, 8);
        hit_n = 0;
        @(negedge clk); hsync_in = 1'b1;            // before edge N
        @(negedge clk);                              // after N
        chk("R9 no change after N", int'(line_count), 0);
        @(negedge clk);                              // after N+1
        chk("R9 no change after N+1", int'(line_count), 0);
        @(negedge clk);                              // after N+2
        chk("R9 count after N+2", int'(line_count), 1);
        chk("R9 hit after N+2", int'(start_hit), 1);
        @(negedge clk);
        chk("R7 hit lasts one clock", int'(start_hit), 0);
        repeat (6) @(negedge clk);
        hsync_in = 1'b0;
        idle(6);

        // R6 saturation without vertical sync, then R4 recovery
        do_reset(2'b00);
        start_line = 10'd1023;
        run_frame(4, 1030, 0, 8);
        chk("R6 saturated count", int'(line_count), 1023);
        chk("R6 single hit at max", hit_n, 1);
        chk("R6 hit line at max", hit_val, 1023);
        start_line = 10'd2;
        run_frame(4, 2, 8, 8);
        chk("R4 count restarts", int'(line_count), 2);
        chk("R4 hit after restart", hit_n, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule